// File: doc/BRIEF.md
# Min-Max Check Node Path Constructor

This block is the check node unit of a non-binary LDPC decoder over GF(32) that uses the Min-max rule. It takes the variable-to-check messages of one check node and loads them in a single cycle. There is one message from each of the `DC` connected variable nodes. Each message holds `NM` (LLR, field element) pairs. The pairs are already normalised and sorted so that LLR rises with position, and position 0 carries the zero-LLR node. For every connected variable node in turn, the block streams out the check-to-variable entries with the smallest LLRs. No two entries in one output vector carry the same field element.

Think of the messages as a trellis with one stage per variable node. A path picks one node from every stage except the stage of the target variable node. The path's LLR is the largest LLR among its nodes. Its field element is the XOR of the node elements. The block emits the all-first-node path first. It then visits every nonzero node (positions 1 to `NM`-1 of all stages) in one global ascending order. The order key is the LLR, and ties go by stage index and then by position. Nodes of the target stage are skipped. Each visited node replaces the first node of its own stage in the first path, which gives a candidate whose LLR is that node's LLR. A candidate whose element has already been emitted for this target is dropped.

Entries leave one per cycle with the target index and a flag on the final entry of each target. No intermediate forward or backward results are stored.

Top module: `mm_check_path_gen`

## Requirements
- R1: After reset, `busy` and `out_valid` are low, and `out_valid` stays low in every cycle that follows a cycle with `busy` low.
- R2: The first entry emitted for target t has LLR equal to the maximum of the position-0 LLRs of all stages other than t (zero for normalised input). Its element is the XOR of the position-0 elements of all stages other than t.
- R3: Within one target, emitted LLRs never decrease.
- R4: Every later entry comes from one nonzero node (stage s, position p ≥ 1). Its LLR equals that node's LLR. Its element equals the first entry's element XOR the position-0 element of stage s XOR the node's element.
- R5: Nodes belonging to the target's own stage never produce an entry for that target.
- R6: No two entries emitted for the same target carry the same field element. A candidate with an element already emitted is discarded.
- R7: At most `NM` entries are emitted per target. Construction for a target stops when `NM` entries are out or when every nonzero node has been visited.
- R8: Targets are served in order 0 to `DC`-1. `out_target` gives the target, and `out_last` is high on exactly the final entry of each target.
- R9: Nonzero nodes are visited in ascending LLR order. Equal LLRs are visited by ascending stage index, then ascending position.
- R10: `start` is sampled only while idle. A `start` pulse or a change of the message inputs during a run has no effect on that run's output. `busy` falls after the final entry of target `DC`-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load messages and begin a run (only while idle) |
| msg_llr | input | DC*NM*5 | LLRs; node (s,p) at bits [(s*NM+p)*5 +: 5] |
| msg_elem | input | DC*NM*5 | Field elements; node (s,p) at bits [(s*NM+p)*5 +: 5] |
| busy | output | 1 | Run in progress |
| out_valid | output | 1 | Output entry present this cycle |
| out_last | output | 1 | Final entry of the current target |
| out_target | output | clog2(DC) | Target variable node index |
| out_llr | output | 5 | Entry LLR |
| out_elem | output | 5 | Entry field element (GF(32), XOR addition) |

## Verification
A fault in the visit order or the remembered position shows up at the ports within the same target. An out-of-order or repeated node yields an LLR that does not match the expected stream, or an element already emitted. A corrupted element bitmap or count shows as a missing, extra or duplicated entry, or as `out_last` on the wrong entry, and this is seen no later than the end of that target's stream. Tie-heavy inputs (all LLRs zero) and duplicate-heavy inputs (all elements equal) expose ordering and filtering faults at the first affected entry.

// File: rtl/cnp_pkg.sv
package cnp_pkg;
  localparam int LLR_W  = 5;
  localparam int ELEM_W = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INIT,
    ST_SCAN,
    ST_FLUSH
  } cnp_state_e;
endpackage

// File: rtl/cnp_min_select.sv
// Picks the nonzero node with the smallest {llr, index} key strictly above
// the last visited key, excluding nodes of the target stage.
module cnp_min_select #(
  parameter int DC = 6,
  parameter int NM = 16,
  parameter int LW = 5,
  parameter int EW = 5,
  parameter int TW = 3,
  parameter int IW = 7
) (
  input  logic [DC*(NM-1)*LW-1:0] nz_llr,
  input  logic [DC*(NM-1)*EW-1:0] nz_elem,
  input  logic [TW-1:0]           target,
  input  logic                    have_last,
  input  logic [LW-1:0]           last_llr,
  input  logic [IW-1:0]           last_idx,
  output logic                    found,
  output logic [IW-1:0]           sel_idx,
  output logic [LW-1:0]           sel_llr,
  output logic [EW-1:0]           sel_elem,
  output logic [TW-1:0]           sel_stage
);
  localparam int NZ = NM - 1;

  always_comb begin
    found     = 1'b0;
    sel_idx   = '0;
    sel_llr   = '0;
    sel_elem  = '0;
    sel_stage = '0;
    for (int s = 0; s < DC; s++) begin
      for (int p = 0; p < NZ; p++) begin
        if ((s != int'(target)) &&
            (!have_last ||
             ({nz_llr[(s*NZ+p)*LW +: LW], IW'(s*NZ+p)} > {last_llr, last_idx})) &&
            (!found || (nz_llr[(s*NZ+p)*LW +: LW] < sel_llr))) begin
          found     = 1'b1;
          sel_idx   = IW'(s*NZ+p);
          sel_llr   = nz_llr[(s*NZ+p)*LW +: LW];
          sel_elem  = nz_elem[(s*NZ+p)*EW +: EW];
          sel_stage = TW'(s);
        end
      end
    end
  end
endmodule

// File: rtl/cnp_path_base.sv
// Forms the all-first-node path for a target and the single-swap candidate.
module cnp_path_base #(
  parameter int DC = 6,
  parameter int LW = 5,
  parameter int EW = 5,
  parameter int TW = 3
) (
  input  logic [DC*LW-1:0] first_llr,
  input  logic [DC*EW-1:0] first_elem,
  input  logic [TW-1:0]    target,
  input  logic [TW-1:0]    swap_stage,
  input  logic [EW-1:0]    swap_elem,
  output logic [LW-1:0]    base_llr,
  output logic [EW-1:0]    base_elem,
  output logic [EW-1:0]    cand_elem
);
  logic [EW-1:0] total_elem;
  logic [EW-1:0] tgt_first;
  logic [EW-1:0] swp_first;

  always_comb begin
    total_elem = '0;
    base_llr   = '0;
    tgt_first  = '0;
    swp_first  = '0;
    for (int s = 0; s < DC; s++) begin
      total_elem = total_elem ^ first_elem[s*EW +: EW];
      if (s == int'(target)) tgt_first = first_elem[s*EW +: EW];
      if (s == int'(swap_stage)) swp_first = first_elem[s*EW +: EW];
      if ((s != int'(target)) && (first_llr[s*LW +: LW] > base_llr))
        base_llr = first_llr[s*LW +: LW];
    end
    base_elem = total_elem ^ tgt_first;
    cand_elem = base_elem ^ swp_first ^ swap_elem;
  end
endmodule

// File: rtl/mm_check_path_gen.sv
module mm_check_path_gen #(
  parameter int DC = 6,
  parameter int NM = 16,
  parameter int LW = cnp_pkg::LLR_W,
  parameter int EW = cnp_pkg::ELEM_W,
  parameter int TW = $clog2(DC)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [DC*NM*LW-1:0]   msg_llr,
  input  logic [DC*NM*EW-1:0]   msg_elem,
  output logic                  busy,
  output logic                  out_valid,
  output logic                  out_last,
  output logic [TW-1:0]         out_target,
  output logic [LW-1:0]         out_llr,
  output logic [EW-1:0]         out_elem
);
  import cnp_pkg::*;

  localparam int NZ = NM - 1;
  localparam int K  = DC * NZ;
  localparam int IW = $clog2(K);
  localparam int CW = $clog2(NM + 1);
  localparam int Q  = 1 << EW;

  // message store
  logic [DC*NM*LW-1:0] llr_q;
  logic [DC*NM*EW-1:0] elem_q;
  logic                load_msg;

  // unpacked views
  logic [DC*LW-1:0] first_llr;
  logic [DC*EW-1:0] first_elem;
  logic [K*LW-1:0]  nz_llr;
  logic [K*EW-1:0]  nz_elem;

  // control state
  cnp_state_e    state_q, state_d;
  logic [TW-1:0] target_q, target_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [Q-1:0]  mask_q, mask_d;
  logic          have_last_q, have_last_d;
  logic [LW-1:0] last_llr_q, last_llr_d;
  logic [IW-1:0] last_idx_q, last_idx_d;
  logic [LW-1:0] pend_llr_q, pend_llr_d;
  logic [EW-1:0] pend_elem_q, pend_elem_d;

  // output state
  logic          ov_q, ov_d;
  logic          ol_q, ol_d;
  logic [TW-1:0] ot_q, ot_d;
  logic [LW-1:0] oll_q, oll_d;
  logic [EW-1:0] oe_q, oe_d;

  // selector and path results
  logic          found;
  logic [IW-1:0] sel_idx;
  logic [LW-1:0] sel_llr;
  logic [EW-1:0] sel_elem;
  logic [TW-1:0] sel_stage;
  logic [LW-1:0] base_llr;
  logic [EW-1:0] base_elem;
  logic [EW-1:0] cand_elem;

  logic emit;
  logic emit_last;

  for (genvar s = 0; s < DC; s++) begin : g_stage
    assign first_llr[s*LW +: LW]  = llr_q[(s*NM)*LW +: LW];
    assign first_elem[s*EW +: EW] = elem_q[(s*NM)*EW +: EW];
    for (genvar p = 1; p < NM; p++) begin : g_pos
      assign nz_llr[(s*NZ+p-1)*LW +: LW]  = llr_q[(s*NM+p)*LW +: LW];
      assign nz_elem[(s*NZ+p-1)*EW +: EW] = elem_q[(s*NM+p)*EW +: EW];
    end
  end

  cnp_min_select #(
    .DC(DC), .NM(NM), .LW(LW), .EW(EW), .TW(TW), .IW(IW)
  ) u_sel (
    .nz_llr    (nz_llr),
    .nz_elem   (nz_elem),
    .target    (target_q),
    .have_last (have_last_q),
    .last_llr  (last_llr_q),
    .last_idx  (last_idx_q),
    .found     (found),
    .sel_idx   (sel_idx),
    .sel_llr   (sel_llr),
    .sel_elem  (sel_elem),
    .sel_stage (sel_stage)
  );

  cnp_path_base #(
    .DC(DC), .LW(LW), .EW(EW), .TW(TW)
  ) u_base (
    .first_llr  (first_llr),
    .first_elem (first_elem),
    .target     (target_q),
    .swap_stage (sel_stage),
    .swap_elem  (sel_elem),
    .base_llr   (base_llr),
    .base_elem  (base_elem),
    .cand_elem  (cand_elem)
  );

  // next-state logic
  always_comb begin
    state_d     = state_q;
    target_d    = target_q;
    cnt_d       = cnt_q;
    mask_d      = mask_q;
    have_last_d = have_last_q;
    last_llr_d  = last_llr_q;
    last_idx_d  = last_idx_q;
    pend_llr_d  = pend_llr_q;
    pend_elem_d = pend_elem_q;
    load_msg    = 1'b0;
    emit        = 1'b0;
    emit_last   = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (start) begin
          load_msg = 1'b1;
          target_d = '0;
          state_d  = ST_INIT;
        end
      end
      ST_INIT: begin
        pend_llr_d  = base_llr;
        pend_elem_d = base_elem;
        cnt_d       = CW'(1);
        mask_d      = Q'(1) << base_elem;
        have_last_d = 1'b0;
        state_d     = ST_SCAN;
      end
      ST_SCAN: begin
        if ((cnt_q == CW'(NM)) || !found) begin
          state_d = ST_FLUSH;
        end else begin
          have_last_d = 1'b1;
          last_llr_d  = sel_llr;
          last_idx_d  = sel_idx;
          if (!mask_q[cand_elem]) begin
            emit              = 1'b1;
            pend_llr_d        = sel_llr;
            pend_elem_d       = cand_elem;
            mask_d[cand_elem] = 1'b1;
            cnt_d             = cnt_q + CW'(1);
          end
        end
      end
      ST_FLUSH: begin
        emit      = 1'b1;
        emit_last = 1'b1;
        if (target_q == TW'(DC - 1)) begin
          state_d = ST_IDLE;
        end else begin
          target_d = target_q + TW'(1);
          state_d  = ST_INIT;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    ov_d  = emit;
    ol_d  = ol_q;
    ot_d  = ot_q;
    oll_d = oll_q;
    oe_d  = oe_q;
    if (emit) begin
      ol_d  = emit_last;
      ot_d  = target_q;
      oll_d = pend_llr_q;
      oe_d  = pend_elem_q;
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      target_q    <= '0;
      cnt_q       <= '0;
      mask_q      <= '0;
      have_last_q <= 1'b0;
      last_llr_q  <= '0;
      last_idx_q  <= '0;
      pend_llr_q  <= '0;
      pend_elem_q <= '0;
      ov_q        <= 1'b0;
      ol_q        <= 1'b0;
      ot_q        <= '0;
      oll_q       <= '0;
      oe_q        <= '0;
    end else begin
      state_q     <= state_d;
      target_q    <= target_d;
      cnt_q       <= cnt_d;
      mask_q      <= mask_d;
      have_last_q <= have_last_d;
      last_llr_q  <= last_llr_d;
      last_idx_q  <= last_idx_d;
      pend_llr_q  <= pend_llr_d;
      pend_elem_q <= pend_elem_d;
      ov_q        <= ov_d;
      ol_q        <= ol_d;
      ot_q        <= ot_d;
      oll_q       <= oll_d;
      oe_q        <= oe_d;
    end
  end

  // message store, loaded only on an accepted start
  always_ff @(posedge clk) begin
    if (load_msg) begin
      llr_q  <= msg_llr;
      elem_q <= msg_elem;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign out_valid  = ov_q;
  assign out_last   = ol_q;
  assign out_target = ot_q;
  assign out_llr    = oll_q;
  assign out_elem   = oe_q;
endmodule

// File: rtl/mm_check_path_gen_chk.sv
module mm_check_path_gen_chk #(
  parameter int DC = 6,
  parameter int NM = 16,
  parameter int LW = 5,
  parameter int EW = 5,
  parameter int TW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          out_valid,
  input logic          out_last,
  input logic [TW-1:0] out_target,
  input logic [LW-1:0] out_llr,
  input logic [EW-1:0] out_elem
);
  localparam int Q  = 1 << EW;
  localparam int CW = $clog2(NM + 1);

  logic [Q-1:0]  seen_q;
  logic          in_tgt_q;
  logic [LW-1:0] prev_llr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q     <= '0;
      in_tgt_q   <= 1'b0;
      prev_llr_q <= '0;
      cnt_q      <= '0;
    end else if (out_valid) begin
      if (out_last) begin
        seen_q   <= '0;
        in_tgt_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        seen_q[out_elem] <= 1'b1;
        in_tgt_q         <= 1'b1;
        prev_llr_q       <= out_llr;
        cnt_q            <= cnt_q + CW'(1);
      end
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !out_valid);

  assert_llr_rising_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && in_tgt_q) |-> (out_llr >= prev_llr_q));

  assert_unique_elem_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !seen_q[out_elem]);

  assert_count_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (cnt_q < CW'(NM)));

  assert_target_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_target) < DC));
endmodule

bind mm_check_path_gen mm_check_path_gen_chk #(
  .DC(DC), .NM(NM), .LW(LW), .EW(EW), .TW(TW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .out_valid  (out_valid),
  .out_last   (out_last),
  .out_target (out_target),
  .out_llr    (out_llr),
  .out_elem   (out_elem)
);

// File: tb/mm_check_path_gen_test.sv
module mm_check_path_gen_test;
  localparam int PERIOD = 10;
  localparam int DC = 6;
  localparam int NM = 16;
  localparam int LW = 5;
  localparam int EW = 5;
  localparam int TW = 3;

  logic                clk;
  logic                rst_n;
  logic                start;
  logic [DC*NM*LW-1:0] msg_llr;
  logic [DC*NM*EW-1:0] msg_elem;
  logic                busy;
  logic                out_valid;
  logic                out_last;
  logic [TW-1:0]       out_target;
  logic [LW-1:0]       out_llr;
  logic [EW-1:0]       out_elem;

  int n_checks = 0;
  int n_fail   = 0;

  logic [LW-1:0] m_llr  [DC][NM];
  logic [EW-1:0] m_elem [DC][NM];
  int exp_llr  [DC][NM];
  int exp_elem [DC][NM];
  int exp_cnt  [DC];

  mm_check_path_gen #(.DC(DC), .NM(NM), .LW(LW), .EW(EW), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .msg_llr(msg_llr), .msg_elem(msg_elem),
    .busy(busy), .out_valid(out_valid), .out_last(out_last),
    .out_target(out_target), .out_llr(out_llr), .out_elem(out_elem)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // mode 0 random, 1 all LLRs zero, 2 all elements zero, 3 high LLRs
  task automatic gen(input int mode);
    for (int s = 0; s < DC; s++) begin
      int cur = (mode == 3) ? 25 : 0;
      m_llr[s][0]  = '0;
      m_elem[s][0] = (mode == 2) ? '0 : EW'($urandom % 32);
      for (int p = 1; p < NM; p++) begin
        if (mode == 0 || mode == 2) cur = cur + int'($urandom % 3);
        if (mode == 3) cur = cur + int'($urandom % 2);
        if (cur > 31) cur = 31;
        m_llr[s][p]  = (mode == 1) ? '0 : LW'(cur);
        m_elem[s][p] = (mode == 2) ? '0 : EW'($urandom % 32);
      end
    end
  endtask

  task automatic model();
    for (int t = 0; t < DC; t++) begin
      int base_e = 0;
      int base_l = 0;
      int cnt = 0;
      bit [31:0] mask = '0;
      for (int s = 0; s < DC; s++) begin
        if (s != t) begin
          base_e = base_e ^ int'(m_elem[s][0]);
          if (int'(m_llr[s][0]) > base_l) base_l = int'(m_llr[s][0]);
        end
      end
      exp_llr[t][0] = base_l; exp_elem[t][0] = base_e;
      mask[base_e] = 1'b1; cnt = 1;
      for (int v = 0; v < 32; v++)
        for (int s = 0; s < DC; s++)
          for (int p = 1; p < NM; p++)
            if (s != t && int'(m_llr[s][p]) == v && cnt < NM) begin
              int e = base_e ^ int'(m_elem[s][0]) ^ int'(m_elem[s][p]);
              if (!mask[e]) begin
                mask[e] = 1'b1;
                exp_llr[t][cnt] = v; exp_elem[t][cnt] = e;
                cnt++;
              end
            end
      exp_cnt[t] = cnt;
    end
  endtask

  task automatic pack();
    for (int s = 0; s < DC; s++)
      for (int p = 0; p < NM; p++) begin
        msg_llr[(s*NM+p)*LW +: LW]  = m_llr[s][p];
        msg_elem[(s*NM+p)*EW +: EW] = m_elem[s][p];
      end
  endtask

  task automatic run_set(input int mode, input bit inject);
    int cur_t = 0;
    int ptr = 0;
    int cyc = 0;
    gen(mode);
    model();
    pack();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R10 busy after start", int'(busy), 1);
    while (cur_t < DC && cyc < 3000) begin
      if (inject && cyc == 20) begin
        start = 1'b1;          // R10: ignored while busy
        msg_llr = ~msg_llr;
        msg_elem = ~msg_elem;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
      if (out_valid) begin
        check(int'(out_target) == cur_t, "R8 target order", int'(out_target), cur_t);
        if (ptr < exp_cnt[cur_t]) begin
          if (ptr == 0) begin
            check(int'(out_llr) == exp_llr[cur_t][0], "R2 first llr", int'(out_llr), exp_llr[cur_t][0]);
            check(int'(out_elem) == exp_elem[cur_t][0], "R2 first elem", int'(out_elem), exp_elem[cur_t][0]);
          end else begin
            check(int'(out_llr) == exp_llr[cur_t][ptr], "R3 R4 R5 R9 llr", int'(out_llr), exp_llr[cur_t][ptr]);
            check(int'(out_elem) == exp_elem[cur_t][ptr], "R4 R6 R9 elem", int'(out_elem), exp_elem[cur_t][ptr]);
          end
        end else begin
          check(1'b0, "R7 extra entry", ptr + 1, exp_cnt[cur_t]);
        end
        check(out_last == (ptr == exp_cnt[cur_t] - 1), "R7 R8 last flag", int'(out_last),
              int'(ptr == exp_cnt[cur_t] - 1));
        ptr++;
        if (out_last) begin
          cur_t++;
          ptr = 0;
        end
      end
    end
    start = 1'b0;
    check(cyc < 3000, "R8 run completes", cyc, 3000);
    @(negedge clk);
    check(busy == 1'b0 && out_valid == 1'b0, "R10 idle after run", int'(busy), 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    start = 1'b0;
    msg_llr = '0;
    msg_elem = '0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    check(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R1 idle valid", int'(out_valid), 0);

    run_set(1, 1'b0);   // R9 all ties
    run_set(2, 1'b0);   // R6 R7 every candidate duplicate
    run_set(3, 1'b0);   // high LLRs
    run_set(0, 1'b1);   // R10 start and inputs disturbed mid-run
    for (int i = 0; i < 20; i++) run_set(0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule